// File: doc/BRIEF.md
# Dual-Output PWM Timer Channel

One channel of a general-purpose PWM timer. A 32-bit counter advances on ticks from a power-of-four prescaler. It runs as an up or down sawtooth, or as an up/down triangle, bounded by a period register. Two compare registers each own one output pin. When the counter's new value equals a pin's compare value, the pin toggles. A per-pin action code sets the pin's level at configuration time and again at the end of every cycle. The counter reports a one-clock overflow pulse at its top and a one-clock underflow pulse at its bottom.

All configuration arrives through a single-cycle write port: address, data and a write strobe. Software programs the period, the compare values, the pin behaviour and the direction while the channel is stopped. It may preload the counter, and then sets the run bit. Compare and period writes take effect on the next counting step, because there is no shadow buffering.

Top module: `pwm_dual_channel`

## Requirements
- R1: Writes are accepted on a clock where `wr_en_i` is high. Register addresses: 0 control, 1 direction, 2 pin configuration, 3 counter load, 4 compare A, 5 compare B, 6 period.
- R2: After reset the counter is 0, both pins are low, both event pulses are low, the period is 0xFFFFFFFF and counting is stopped and set to up.
- R3: Sawtooth mode (control bits 18:16 equal to 0) with the direction up bit set: each tick increments the counter. A tick that finds the counter at or above the period loads 0 instead, and `ovf_o` is high for exactly that one clock.
- R4: Sawtooth mode with the up bit clear: each tick decrements the counter. A tick that finds 0 loads the period instead, and `udf_o` is high for one clock.
- R5: Triangle mode (control bits 18:16 nonzero): counting up, a tick at or above the period reverses to down, loads period-1 and pulses `ovf_o`. Counting down, a tick at 0 reverses to up, loads 1 and pulses `udf_o`.
- R6: Direction register: bit 0 is the up bit and bit 1 is the force bit. A write with bit 1 set loads the triangle's running direction from bit 0 at once. A write with bit 1 clear leaves the running triangle direction unchanged.
- R7: Control bits 26:24 select a divide of 4^n for n = 0..5, so the counter advances once every 4^n clocks after start. Values 6 and 7 divide by 1024.
- R8: Control bit 0 runs the counter when set. While it is clear, the counter and both pins hold their values.
- R9: A write to the counter-load address sets the counter on the next clock. It takes priority over a counting step at that edge, and it raises neither event.
- R10: Pin action codes are at bits 4:0 (pin A) and bits 20:16 (pin B). Code 0x07 loads low on write and returns low at each cycle end. Code 0x1B does the same with high. Both toggle when the counter's new value equals the pin's compare. A cycle end takes priority over a match. The cycle end is the `ovf_o` step in up sawtooth, the `udf_o` step in down sawtooth and the trough in triangle.
- R11: Any other action code holds the pin at the level of the code's bit 4 and never toggles.
- R12: Output-enable bits are bit 8 (pin A) and bit 24 (pin B). A pin whose enable is clear is driven low.
- R13: Compare and period writes take effect on the next counting step. The full 32-bit period 0xFFFFFFFF wraps correctly from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| count_o | output | 32 | Current counter value |
| pin_a_o | output | 1 | Output pin A (compare A) |
| pin_b_o | output | 1 | Output pin B (compare B) |
| ovf_o | output | 1 | One-clock overflow pulse |
| udf_o | output | 1 | One-clock underflow pulse |

## Verification
The hardest situations to reach are the two ends of the 32-bit range and the triangle turn-around points. At a turn-around, a compare match and the direction change land on the same step. Waiting for a natural wrap at period 0xFFFFFFFF would take billions of clocks. The stimulus therefore preloads the counter to 0xFFFFFFFE through the load address, and separately fires a load on the very edge where a wrap would occur. For the triangle, the period and compare values are chosen so that the crest step produces a match and the trough step coincides with the cycle-end level. A forced direction write then starts the triangle downward from a preloaded value.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_DIR    = 3'd1;
  localparam logic [ADDR_W-1:0] REG_PIN    = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CNT    = 3'd3;
  localparam logic [ADDR_W-1:0] REG_CMP0   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_PERIOD = 3'd6;

  // control word fields
  localparam int RUN_BIT  = 0;
  localparam int MODE_LSB = 16;
  localparam int PSC_LSB  = 24;

  // direction word fields
  localparam int DIR_UP_BIT    = 0;
  localparam int DIR_FORCE_BIT = 1;

  // pin word: pin i field starts at PIN_STRIDE*i
  localparam int PIN_STRIDE = 16;
  localparam int OE_OFS     = 8;
  localparam int ACT_W      = 5;

  localparam logic [ACT_W-1:0] ACT_LO_TOGGLE = 5'h07;
  localparam logic [ACT_W-1:0] ACT_HI_TOGGLE = 5'h1B;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W   = 3,
  parameter int MAX_EXP = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = 2 * MAX_EXP;

  logic [PSC_W-1:0] exp_eff;
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] pre_q;

  // out-of-range select saturates at the largest divide
  always_comb begin
    exp_eff = (sel_i > PSC_W'(MAX_EXP)) ? PSC_W'(MAX_EXP) : sel_i;
    limit   = '0;
    for (int i = 0; i < MAX_EXP; i++) begin
      if (PSC_W'(i) < exp_eff) limit[2*i +: 2] = 2'b11;
    end
  end

  assign tick_o = run_i && (pre_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!run_i)  pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + DIV_W'(1);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tri_i,
  input  logic         up_i,
  input  logic         force_i,
  input  logic         force_up_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         cycle_end_o,
  output logic         ovf_o,
  output logic         udf_o
);
  logic [W-1:0] cnt_q;
  logic         tri_up_q, up_n, ovf_n, udf_n;
  logic         ovf_q, udf_q;
  logic         per_zero;

  assign per_zero = (period_i == '0);

  always_comb begin
    cnt_nxt_o = cnt_q;
    up_n      = tri_up_q;
    ovf_n     = 1'b0;
    udf_n     = 1'b0;
    if (!tri_i) begin
      if (up_i) begin
        if (cnt_q >= period_i) begin cnt_nxt_o = '0; ovf_n = 1'b1; end
        else                         cnt_nxt_o = cnt_q + W'(1);
      end else begin
        if (cnt_q == '0) begin cnt_nxt_o = period_i; udf_n = 1'b1; end
        else                   cnt_nxt_o = cnt_q - W'(1);
      end
    end else begin
      if (tri_up_q) begin
        if (cnt_q >= period_i) begin
          up_n      = 1'b0;
          ovf_n     = 1'b1;
          cnt_nxt_o = per_zero ? '0 : period_i - W'(1);
        end else cnt_nxt_o = cnt_q + W'(1);
      end else begin
        if (cnt_q == '0) begin
          up_n      = 1'b1;
          udf_n     = 1'b1;
          cnt_nxt_o = per_zero ? '0 : W'(1);
        end else cnt_nxt_o = cnt_q - W'(1);
      end
    end
  end

  // triangle cycle ends at the trough only
  assign cycle_end_o = tri_i ? udf_n : (ovf_n | udf_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      tri_up_q <= 1'b1;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      ovf_q <= step_i & ovf_n;
      udf_q <= step_i & udf_n;
      if (load_i)      cnt_q <= load_val_i;
      else if (step_i) cnt_q <= cnt_nxt_o;
      if (force_i)     tri_up_q <= force_up_i;
      else if (step_i) tri_up_q <= up_n;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign udf_o = udf_q;
endmodule

// File: rtl/pwm_pin.sv
module pwm_pin
  import pwm_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [ACT_W-1:0] cfg_code_i,
  input  logic             oe_i,
  input  logic             step_i,
  input  logic             cycle_end_i,
  input  logic             match_i,
  output logic             pin_o
);
  logic [ACT_W-1:0] code_q;
  logic             lvl_q;
  logic             toggle_en;

  assign toggle_en = (code_q == ACT_LO_TOGGLE) || (code_q == ACT_HI_TOGGLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      lvl_q  <= 1'b0;
    end else if (cfg_wr_i) begin
      code_q <= cfg_code_i;
      lvl_q  <= cfg_code_i[ACT_W-1];
    end else if (step_i && toggle_en) begin
      if (cycle_end_i)  lvl_q <= code_q[ACT_W-1];
      else if (match_i) lvl_q <= ~lvl_q;
    end
  end

  assign pin_o = oe_i & lvl_q;
endmodule

// File: rtl/pwm_dual_channel.sv
module pwm_dual_channel
  import pwm_chan_pkg::*;
#(
  parameter int DW      = 32,
  parameter int PSC_W   = 3,
  parameter int MODE_W  = 3,
  parameter int MAX_EXP = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     count_o,
  output logic              pin_a_o,
  output logic              pin_b_o,
  output logic              ovf_o,
  output logic              udf_o
);
  localparam int N_PIN = 2;

  logic              run_q, up_q;
  logic [MODE_W-1:0] mode_q;
  logic [PSC_W-1:0]  psc_q;
  logic [DW-1:0]     period_q;
  logic [N_PIN-1:0]  oe_q;
  logic [N_PIN-1:0]  pins;

  logic wr_ctrl, wr_dir, wr_pin, wr_cnt, wr_per;
  logic tick, step, cycle_end;
  logic [DW-1:0] cnt_nxt;

  assign wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);
  assign wr_dir  = wr_en_i && (wr_addr_i == REG_DIR);
  assign wr_pin  = wr_en_i && (wr_addr_i == REG_PIN);
  assign wr_cnt  = wr_en_i && (wr_addr_i == REG_CNT);
  assign wr_per  = wr_en_i && (wr_addr_i == REG_PERIOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      mode_q   <= '0;
      psc_q    <= '0;
      up_q     <= 1'b1;
      period_q <= '1;
      oe_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wr_data_i[RUN_BIT];
        mode_q <= wr_data_i[MODE_LSB +: MODE_W];
        psc_q  <= wr_data_i[PSC_LSB +: PSC_W];
      end
      if (wr_dir) up_q     <= wr_data_i[DIR_UP_BIT];
      if (wr_per) period_q <= wr_data_i;
      if (wr_pin) begin
        for (int i = 0; i < N_PIN; i++) oe_q[i] <= wr_data_i[PIN_STRIDE*i + OE_OFS];
      end
    end
  end

  pwm_prescaler #(.PSC_W(PSC_W), .MAX_EXP(MAX_EXP)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .sel_i  (psc_q),
    .tick_o (tick)
  );

  assign step = tick & ~wr_cnt;

  pwm_counter #(.W(DW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .load_i      (wr_cnt),
    .load_val_i  (wr_data_i),
    .tri_i       (mode_q != '0),
    .up_i        (up_q),
    .force_i     (wr_dir && wr_data_i[DIR_FORCE_BIT]),
    .force_up_i  (wr_data_i[DIR_UP_BIT]),
    .period_i    (period_q),
    .cnt_o       (count_o),
    .cnt_nxt_o   (cnt_nxt),
    .cycle_end_o (cycle_end),
    .ovf_o       (ovf_o),
    .udf_o       (udf_o)
  );

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic [DW-1:0] cmp_q;
    logic          wr_cmp;

    assign wr_cmp = wr_en_i && (wr_addr_i == REG_CMP0 + ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cmp_q <= '0;
      else if (wr_cmp) cmp_q <= wr_data_i;
    end

    pwm_pin u_pin (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_wr_i    (wr_pin),
      .cfg_code_i  (wr_data_i[PIN_STRIDE*g +: ACT_W]),
      .oe_i        (oe_q[g]),
      .step_i      (step),
      .cycle_end_i (cycle_end),
      .match_i     (cnt_nxt == cmp_q),
      .pin_o       (pins[g])
    );
  end

  assign pin_a_o = pins[0];
  assign pin_b_o = pins[1];
endmodule

// File: rtl/pwm_dual_channel_chk.sv
module pwm_dual_channel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_q,
  input logic        wr_en_i,
  input logic [2:0]  wr_addr_i,
  input logic [31:0] count_o,
  input logic [31:0] period_q,
  input logic [1:0]  oe_q,
  input logic        pin_a_o,
  input logic        pin_b_o,
  input logic        ovf_o,
  input logic        udf_o
);
  assert_evt_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && udf_o));

  assert_ovf_at_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> ($past(count_o) >= $past(period_q)));

  assert_udf_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |-> ($past(count_o) == 32'd0));

  assert_hold_stopped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !(wr_en_i && wr_addr_i == 3'd3)) |=> $stable(count_o));

  assert_oe_gate_a_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q[0] |-> !pin_a_o);

  assert_oe_gate_b_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q[1] |-> !pin_b_o);
endmodule

bind pwm_dual_channel pwm_dual_channel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_q     (run_q),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .count_o   (count_o),
  .period_q  (period_q),
  .oe_q      (oe_q),
  .pin_a_o   (pin_a_o),
  .pin_b_o   (pin_b_o),
  .ovf_o     (ovf_o),
  .udf_o     (udf_o)
);

// File: tb/pwm_dual_channel_tb.sv
module pwm_dual_channel_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] count_o;
  logic        pin_a_o, pin_b_o, ovf_o, udf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  string       q_req[$];
  int          q_sel[$];
  logic [31:0] q_exp[$];

  always #10 clk = ~clk;

  pwm_dual_channel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .count_o(count_o), .pin_a_o(pin_a_o),
    .pin_b_o(pin_b_o), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  // monitor: compare queued expectations against state after the last edge
  string       m_req;
  int          m_sel;
  logic [31:0] m_exp, m_act;
  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      m_req = q_req.pop_front();
      m_sel = q_sel.pop_front();
      m_exp = q_exp.pop_front();
      case (m_sel)
        0: m_act = count_o;
        1: m_act = {31'b0, pin_a_o};
        2: m_act = {31'b0, pin_b_o};
        3: m_act = {31'b0, ovf_o};
        default: m_act = {31'b0, udf_o};
      endcase
      checks++;
      if (m_act !== m_exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", m_req, m_sel, m_act, m_exp);
      end
    end
  end

  task automatic push(input string req, input int sel, input logic [31:0] v);
    q_req.push_back(req); q_sel.push_back(sel); q_exp.push_back(v);
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic chk_cnt(input string req, input logic [31:0] c);
    push(req, 0, c);
  endtask

  task automatic chk_ev(input string req, input logic ov, input logic ud);
    push(req, 3, {31'b0, ov}); push(req, 4, {31'b0, ud});
  endtask

  task automatic chk_pins(input string req, input logic pa, input logic pb);
    push(req, 1, {31'b0, pa}); push(req, 2, {31'b0, pb});
  endtask

  task automatic chk_all(input string req, input logic [31:0] c, input logic pa,
                         input logic pb, input logic ov, input logic ud);
    chk_cnt(req, c); chk_pins(req, pa, pb); chk_ev(req, ov, ud);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    chk_all("R2 reset", 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // sawtooth up, period 4, cmp A 2, cmp B 3, A=0x07, B=0x1B, both enabled
    wr(3'd6, 32'd4); wr(3'd4, 32'd2); wr(3'd5, 32'd3);
    wr(3'd2, 32'h011B_0107);
    chk_pins("R1 R10 pin config levels", 1'b0, 1'b1);
    wr(3'd0, 32'h0000_0001);
    chk_cnt("R8 run write edge", 32'd0);
    step(); chk_all("R3 saw step1", 32'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(); chk_all("R10 R13 match A", 32'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    step(); chk_all("R10 match B", 32'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    step(); chk_all("R3 at period", 32'd4, 1'b1, 1'b0, 1'b0, 1'b0);
    step(); chk_all("R3 R10 wrap cycle end", 32'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    step(); chk_all("R3 ovf one clock", 32'd1, 1'b0, 1'b1, 1'b0, 1'b0);

    // stop
    wr(3'd0, 32'h0);
    chk_all("R8 last step", 32'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (3) step();
    chk_all("R8 stopped hold", 32'd2, 1'b1, 1'b1, 1'b0, 1'b0);

    // load while stopped
    wr(3'd3, 32'h10);
    chk_cnt("R9 load stopped", 32'h10);
    step(); chk_all("R9 load hold", 32'h10, 1'b1, 1'b1, 1'b0, 1'b0);

    // prescaler divide 4
    wr(3'd3, 32'd0); wr(3'd6, 32'd100); wr(3'd0, 32'h0100_0001);
    repeat (3) step();
    chk_cnt("R7 div4 before tick", 32'd0);
    step(); chk_cnt("R7 div4 first tick", 32'd1);
    repeat (4) step(); chk_cnt("R7 div4 second tick", 32'd2);

    // prescaler select 7 saturates at 1024
    wr(3'd0, 32'h0); wr(3'd3, 32'd0); wr(3'd0, 32'h0700_0001);
    repeat (1023) step();
    chk_cnt("R7 div1024 before tick", 32'd0);
    step(); chk_cnt("R7 div1024 tick", 32'd1);

    // full-range period
    wr(3'd0, 32'h0); wr(3'd6, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFE);
    wr(3'd0, 32'h0000_0001);
    step(); chk_cnt("R13 max count", 32'hFFFF_FFFF); chk_ev("R13 no ovf", 1'b0, 1'b0);
    step(); chk_cnt("R13 max wrap", 32'd0); chk_ev("R13 max ovf", 1'b1, 1'b0);

    // load on the wrap edge
    wr(3'd6, 32'd4);
    chk_cnt("R13 period write immediate", 32'd1);
    step(); step(); step();
    chk_cnt("R3 reach period", 32'd4);
    wr(3'd3, 32'd2);
    chk_cnt("R9 load beats wrap", 32'd2); chk_ev("R9 no event on load", 1'b0, 1'b0);
    step(); chk_cnt("R9 count after load", 32'd3);

    // sawtooth down
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd6, 32'd3); wr(3'd3, 32'd0);
    wr(3'd0, 32'h0000_0001);
    step(); chk_cnt("R4 reload period", 32'd3); chk_ev("R4 udf", 1'b0, 1'b1);
    step(); chk_cnt("R4 dec", 32'd2); chk_ev("R4 udf one clock", 1'b0, 1'b0);
    step(); step(); chk_cnt("R4 at zero", 32'd0);
    step(); chk_cnt("R4 second reload", 32'd3); chk_ev("R4 udf again", 1'b0, 1'b1);

    // triangle, period 3, cmp A 2, cmp B 3
    wr(3'd0, 32'h0); wr(3'd1, 32'd3); wr(3'd6, 32'd3); wr(3'd3, 32'd0);
    wr(3'd2, 32'h011B_0107);
    wr(3'd0, 32'h0001_0001);
    step(); chk_all("R5 tri up1", 32'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(); chk_all("R5 R10 tri match A up", 32'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    step(); chk_all("R5 R10 tri match B", 32'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    step(); chk_all("R5 R10 crest ovf and match A", 32'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    step(); chk_all("R5 tri down", 32'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(); chk_all("R5 tri zero", 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(); chk_all("R5 R10 trough udf cycle end", 32'd1, 1'b0, 1'b1, 1'b0, 1'b1);
    step(); chk_all("R5 tri up again", 32'd2, 1'b1, 1'b1, 1'b0, 1'b0);

    // forced direction down
    wr(3'd0, 32'h0); wr(3'd3, 32'd1); wr(3'd1, 32'd2); wr(3'd0, 32'h0001_0001);
    step(); chk_cnt("R6 forced down", 32'd0);

    // direction write without force bit leaves triangle direction
    wr(3'd0, 32'h0); wr(3'd1, 32'd3); wr(3'd1, 32'd0); wr(3'd3, 32'd1);
    wr(3'd0, 32'h0001_0001);
    step(); chk_cnt("R6 unforced ignored", 32'd2);

    // other code on A, enable cleared on B
    wr(3'd2, 32'h001B_0110);
    chk_pins("R11 R12 config", 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(); chk_pins("R11 R12 hold while running", 1'b1, 1'b0);
    end

    @(negedge clk); #1;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule